// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Transmitter

This block takes pairs of 20-bit two's-complement samples, one for the left channel and one for the right, and shifts them out on a single serial data line. It does not generate any clocks. The bit clock and the frame clock come from outside the block. Both are sampled in the core clock domain, and that clock must run at least four times faster than the bit clock. A two-bit format input chooses the framing. Three codes give MSB-justified framing. The fourth gives the I2S convention: the frame-clock polarity is inverted and the MSB is delayed by one slot.

The block does not need to be told the bit-clock ratio. It counts the bit-clock falling edges between frame-clock transitions and accepts a half-frame length of 16, 20 or 32 slots. The line stays at zero until one full half-frame of an accepted length has been measured. If a later half-frame has a different length, the block goes silent and measures again. Short half-frames cut off the low-order bits. Long half-frames pad the unused slots with zeros. A new sample pair can be loaded at any time. It is moved into the outgoing frame only when a left half-frame begins.

There are three states. IDLE lasts until the first frame-clock transition. MEASURE times a half-frame. LOCKED means the data line is live. The transitions are:
- IDLE→MEASURE on the first boundary.
- MEASURE→LOCKED when a boundary closes a half-frame of an accepted length.
- MEASURE→MEASURE on a boundary with any other length.
- LOCKED→LOCKED while the lengths keep matching.
- LOCKED→MEASURE on a boundary whose length differs from the locked one.

Top module: `audio_fmt_tx`

## Requirements
- R1: The format code on `fmt_sel` sets the frame-clock polarity. With codes 0, 1 and 2, `lrck`=1 selects the left word. With code 3, `lrck`=0 selects the left word.
- R2: The word is sent MSB first. With codes 0–2, slot k of a half-frame (k=0 is the slot that starts on the boundary fall) carries bit 19−k of the word for k<20.
- R3: `sdata` changes only in the core-clock cycle right after a sampled bit-clock falling edge, and is stable otherwise.
- R4: With code 3, slot 0 carries 0 and slot k≥1 carries bit 20−k, for k≤20.
- R5: In a 16-slot half-frame, only bits 19..4 are sent with codes 0–2, and only bits 19..5 with code 3. The lower bits are dropped.
- R6: Every slot after the last data bit carries 0, for example slots 20..31 of a 32-slot half-frame in codes 0–2.
- R7: The loaded pair is moved into the outgoing frame at the first fall of each left half-frame. A load during a frame does not change that frame's data.
- R8: `sdata` is 0 until a half-frame of 16, 20 or 32 slots has been measured between two boundaries. Any other length, such as 24, never locks the block.
- R9: While LOCKED, a half-frame whose length differs from the locked length sends the block back to MEASURE. The following half-frame is silent, and the block relocks at its end if that half-frame's length is accepted.
- R10: During and after reset, `sdata` is 0 and the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples the bit and frame clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | External bit clock |
| lrck | input | 1 | External frame clock |
| fmt_sel | input | 2 | Framing code (0–2 MSB-justified, 3 I2S) |
| smp_left | input | 20 | Left sample, two's complement |
| smp_right | input | 20 | Right sample, two's complement |
| smp_load | input | 1 | Captures the sample inputs into the holding register |
| sdata | output | 1 | Serial data output |

## Verification
The bench builds the block with its default values: a 20-bit word, a 6-bit saturating slot counter and accepted half-frame lengths of 16, 20 and 32. With these values, all four format codes can be exercised at every accepted ratio. The tests cover truncation of short frames, zero padding of long frames, and a rejected 24-slot length. Changes of ratio and of frame-clock polarity between runs also exercise the unlock and relock path.

// File: rtl/audio_fmt_tx_pkg.sv
package audio_fmt_tx_pkg;

    typedef enum logic [1:0] {
        LK_IDLE    = 2'd0,
        LK_MEASURE = 2'd1,
        LK_LOCKED  = 2'd2
    } lock_state_t;

    localparam logic [1:0] FMT_I2S = 2'd3;

    // Frame-clock level that marks the left half-frame for a format code.
    function automatic logic left_level(input logic [1:0] fmt);
        return (fmt == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/sclk_event_detect.sv
module sclk_event_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic lrck,
    output logic tick,
    output logic boundary
);

    logic sclk_q;
    logic lr_last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            lr_last_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (tick) begin
                lr_last_q <= lrck;
            end
        end
    end

    always_comb begin
        tick     = sclk_q & ~sclk;
        boundary = tick & (lrck != lr_last_q);
    end

endmodule

// File: rtl/ratio_tracker.sv
module ratio_tracker
    import audio_fmt_tx_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int SLOTS_A = 16,
    parameter int SLOTS_B = 20,
    parameter int SLOTS_C = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              boundary,
    output lock_state_t       state_q,
    output lock_state_t       state_n,
    output logic [CNT_W-1:0]  slot_q,
    output logic [CNT_W-1:0]  slot_n,
    output logic [CNT_W:0]    ratio_q
);

    localparam logic [CNT_W-1:0] SLOT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W:0]   LEN_A    = (CNT_W+1)'(SLOTS_A);
    localparam logic [CNT_W:0]   LEN_B    = (CNT_W+1)'(SLOTS_B);
    localparam logic [CNT_W:0]   LEN_C    = (CNT_W+1)'(SLOTS_C);

    logic [CNT_W:0] len_meas;
    logic           len_ok;
    logic [CNT_W:0] ratio_n;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            slot_q  <= '0;
            ratio_q <= '0;
        end else begin
            state_q <= state_n;
            slot_q  <= slot_n;
            ratio_q <= ratio_n;
        end
    end

    always_comb begin
        len_meas = {1'b0, slot_q} + 1'b1;
        len_ok   = (len_meas == LEN_A) || (len_meas == LEN_B) || (len_meas == LEN_C);
    end

    // Next-state process
    always_comb begin
        state_n = state_q;
        ratio_n = ratio_q;
        if (boundary) begin
            unique case (state_q)
                LK_IDLE: begin
                    state_n = LK_MEASURE;
                end
                LK_MEASURE: begin
                    if (len_ok) begin
                        state_n = LK_LOCKED;
                        ratio_n = len_meas;
                    end
                end
                LK_LOCKED: begin
                    if (len_meas != ratio_q) begin
                        state_n = LK_MEASURE;
                    end
                end
                default: begin
                    state_n = LK_IDLE;
                end
            endcase
        end
    end

    // Slot position process
    always_comb begin
        slot_n = slot_q;
        if (tick) begin
            if (boundary) begin
                slot_n = '0;
            end else if (slot_q != SLOT_MAX) begin
                slot_n = slot_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/frame_store.sv
module frame_store #(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    input  logic              capture,
    output logic [DATA_W-1:0] word_l_n,
    output logic [DATA_W-1:0] word_r_n
);

    logic [DATA_W-1:0] hold_l_q, hold_r_q;
    logic [DATA_W-1:0] frm_l_q, frm_r_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l_q <= '0;
            hold_r_q <= '0;
            frm_l_q  <= '0;
            frm_r_q  <= '0;
        end else begin
            if (load) begin
                hold_l_q <= left_in;
                hold_r_q <= right_in;
            end
            frm_l_q <= word_l_n;
            frm_r_q <= word_r_n;
        end
    end

    always_comb begin
        word_l_n = capture ? hold_l_q : frm_l_q;
        word_r_n = capture ? hold_r_q : frm_r_q;
    end

endmodule

// File: rtl/slot_serializer.sv
module slot_serializer
    import audio_fmt_tx_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        fmt,
    input  logic              is_left,
    input  logic              live_n,
    input  logic [CNT_W-1:0]  slot_n,
    input  logic [DATA_W-1:0] word_l,
    input  logic [DATA_W-1:0] word_r,
    output logic              sdata
);

    logic [DATA_W-1:0] word_sel;
    logic [DATA_W-1:0] word_sh;
    logic [CNT_W-1:0]  data_pos;
    logic              delayed;
    logic              bit_n;

    always_comb begin
        delayed  = (fmt == FMT_I2S);
        word_sel = is_left ? word_l : word_r;
        data_pos = slot_n - CNT_W'(delayed);
        word_sh  = word_sel << data_pos;
        if (!live_n) begin
            bit_n = 1'b0;
        end else if (delayed && (slot_n == '0)) begin
            bit_n = 1'b0;
        end else begin
            bit_n = word_sh[DATA_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata <= 1'b0;
        end else if (tick) begin
            sdata <= bit_n;
        end
    end

endmodule

// File: rtl/audio_fmt_tx.sv
module audio_fmt_tx
    import audio_fmt_tx_pkg::*;
#(
    parameter int DATA_W  = 20,
    parameter int CNT_W   = 6,
    parameter int SLOTS_A = 16,
    parameter int SLOTS_B = 20,
    parameter int SLOTS_C = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              lrck,
    input  logic [1:0]        fmt_sel,
    input  logic [DATA_W-1:0] smp_left,
    input  logic [DATA_W-1:0] smp_right,
    input  logic              smp_load,
    output logic              sdata
);

    logic              tick;
    logic              boundary;
    lock_state_t       lk_state;
    lock_state_t       lk_state_n;
    logic [CNT_W-1:0]  slot_q;
    logic [CNT_W-1:0]  slot_n;
    logic [CNT_W:0]    ratio_q;
    logic              is_left;
    logic              capture;
    logic [DATA_W-1:0] word_l;
    logic [DATA_W-1:0] word_r;

    always_comb begin
        is_left = (lrck == left_level(fmt_sel));
        capture = boundary & is_left;
    end

    sclk_event_detect u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .lrck     (lrck),
        .tick     (tick),
        .boundary (boundary)
    );

    ratio_tracker #(
        .CNT_W   (CNT_W),
        .SLOTS_A (SLOTS_A),
        .SLOTS_B (SLOTS_B),
        .SLOTS_C (SLOTS_C)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .boundary (boundary),
        .state_q  (lk_state),
        .state_n  (lk_state_n),
        .slot_q   (slot_q),
        .slot_n   (slot_n),
        .ratio_q  (ratio_q)
    );

    frame_store #(
        .DATA_W (DATA_W)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (smp_load),
        .left_in  (smp_left),
        .right_in (smp_right),
        .capture  (capture),
        .word_l_n (word_l),
        .word_r_n (word_r)
    );

    slot_serializer #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .fmt     (fmt_sel),
        .is_left (is_left),
        .live_n  (lk_state_n == LK_LOCKED),
        .slot_n  (slot_n),
        .word_l  (word_l),
        .word_r  (word_r),
        .sdata   (sdata)
    );

endmodule

// File: rtl/audio_fmt_tx_checker.sv
module audio_fmt_tx_checker
    import audio_fmt_tx_pkg::*;
#(
    parameter int DATA_W  = 20,
    parameter int CNT_W   = 6,
    parameter int SLOTS_A = 16,
    parameter int SLOTS_B = 20,
    parameter int SLOTS_C = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             boundary,
    input logic             sdata,
    input lock_state_t      lk_state,
    input logic [CNT_W-1:0] slot_q,
    input logic [CNT_W:0]   ratio_q
);

    assert_stable_between_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sdata));

    assert_silent_unless_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state != LK_LOCKED) |-> !sdata);

    assert_slot_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (slot_q == '0));

    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(slot_q) > DATA_W) |-> !sdata);

    assert_ratio_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state == LK_LOCKED) |-> ((int'(ratio_q) == SLOTS_A) ||
                                     (int'(ratio_q) == SLOTS_B) ||
                                     (int'(ratio_q) == SLOTS_C)));

    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (lk_state == LK_IDLE) && !sdata);

endmodule

bind audio_fmt_tx audio_fmt_tx_checker #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .SLOTS_A (SLOTS_A),
    .SLOTS_B (SLOTS_B),
    .SLOTS_C (SLOTS_C)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .boundary (boundary),
    .sdata    (sdata),
    .lk_state (lk_state),
    .slot_q   (slot_q),
    .ratio_q  (ratio_q)
);

// File: tb/audio_fmt_tx_bench.sv
module audio_fmt_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        lrck = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [19:0] smp_left = '0;
    logic [19:0] smp_right = '0;
    logic        smp_load = 1'b0;
    logic        sdata;

    always #4 clk = ~clk;

    audio_fmt_tx u_audio_fmt_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .lrck      (lrck),
        .fmt_sel   (fmt_sel),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .smp_load  (smp_load),
        .sdata     (sdata)
    );

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 0;
    string cur_req = "R10";

    // Reference model state
    int          m_lr = 0;
    int          m_cnt = 0;
    int          m_state = 0;     // 0 idle, 1 measure, 2 locked
    int          m_ratio = 0;
    logic [19:0] h_l = '0, h_r = '0;
    logic [19:0] f_l = '0, f_r = '0;
    logic        exp_sd = 1'b0;

    function automatic logic exp_bit(int slot, logic [19:0] w, bit i2s);
        int pos;
        pos = slot - (i2s ? 1 : 0);
        if (pos < 0 || pos >= 20) return 1'b0;
        return w[19-pos];
    endfunction

    task automatic cyc();
        @(negedge clk);
        compared++;
        if (sdata !== exp_sd) begin
            mismatched++;
            $display("FAIL %s t=%0t sdata=%b expected=%b", cur_req, $time, sdata, exp_sd);
        end
    endtask

    task automatic model_fall(int lr);
        int  len;
        int  lft;
        bit  i2s;
        i2s = (fmt_sel == 2'd3);
        lft = i2s ? 0 : 1;
        if (lr != m_lr) begin
            len = m_cnt + 1;
            case (m_state)
                0: m_state = 1;
                1: if (len == 16 || len == 20 || len == 32) begin
                       m_state = 2;
                       m_ratio = len;
                   end
                default: if (len != m_ratio) m_state = 1;
            endcase
            m_cnt = 0;
            if (lr == lft) begin
                f_l = h_l;
                f_r = h_r;
            end
        end else if (m_cnt < 63) begin
            m_cnt++;
        end
        m_lr = lr;
        if (m_state == 2)
            exp_sd = exp_bit(m_cnt, (lr == lft) ? f_l : f_r, i2s);
        else
            exp_sd = 1'b0;
    endtask

    task automatic do_slot(int lr);
        sclk = 1'b0;
        lrck = lr[0];
        model_fall(lr);
        cyc();
        cyc();
        sclk = 1'b1;
        cyc();
        cyc();
    endtask

    task automatic do_load(logic [19:0] l, logic [19:0] r);
        smp_left  = l;
        smp_right = r;
        smp_load  = 1'b1;
        cyc();
        smp_load  = 1'b0;
        h_l = l;
        h_r = r;
        cyc();
    endtask

    task automatic half(int lr, int n);
        for (int s = 0; s < n; s++) do_slot(lr);
    endtask

    task automatic frames(logic [1:0] f, int n, int count);
        int lft;
        fmt_sel = f;
        lft = (f == 2'd3) ? 0 : 1;
        for (int k = 0; k < count; k++) begin
            half(lft, n);
            half(1 - lft, n);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        cur_req = "R10";
        repeat (3) cyc();
        rst_n = 1'b1;
        repeat (3) cyc();

        // R8 lock, R1 left on high, R2 MSB first, R6 padding in 32-slot halves
        cur_req = "R8/R1/R2/R6";
        do_load(20'hA5C3F, 20'h3C96A);
        frames(2'd0, 32, 3);

        // R7: load mid left half must not disturb current frame
        cur_req = "R7";
        half(1, 5);
        do_load(20'h80001, 20'h7FFFE);
        half(1, 27);
        half(0, 32);
        frames(2'd0, 32, 1);

        // R9: ratio change 32 -> 20 slots, silent half then relock
        cur_req = "R9/R2";
        do_load(20'h12345, 20'hFEDCB);
        frames(2'd1, 20, 3);

        // R4/R5: I2S with 16-slot halves, polarity reversed (R1)
        cur_req = "R4/R5/R1";
        do_load(20'hF0F0F, 20'h5AA5A);
        frames(2'd3, 16, 4);

        // R4/R6: I2S with 32 slots
        cur_req = "R4/R6";
        frames(2'd3, 32, 2);

        // R5: justified with 16 slots, code 2
        cur_req = "R5";
        do_load(20'hC0035, 20'h0FFF1);
        frames(2'd2, 16, 3);

        // R8: illegal 24-slot halves never lock
        cur_req = "R8";
        frames(2'd0, 24, 3);

        // R9: relock at 20 slots after illegal lengths
        cur_req = "R9";
        frames(2'd0, 20, 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule